// File: doc/BRIEF.md
# Quarter-Rate Sample-Locked PI Tracking Loop

This block closes a digital control loop around a sinusoid sampled at four times its own frequency. Out of every group of four valid input samples it keeps exactly one. It subtracts a programmable set point from that sample and passes the difference through a proportional-integral controller. The controller's result is a signed 14-bit word for a DAC, which retunes the external oscillator that feeds the ADC. With the set point at zero the loop holds the kept sample on a zero crossing of the waveform. With the set point near the expected amplitude it holds the kept sample on the crest.

A two-state machine governs the loop. In `ST_HOLD` the integrator is cleared and the DAC word follows the programmable mid-scale value. The `arm` transition (enable high) moves to `ST_TRACK`, where each kept sample updates the output. The `drop` transition (enable low) returns to `ST_HOLD`.

Top module: `pi_track_loop`

## Requirements
- R1: While reset is asserted the DAC word is 0.
- R2: Valid samples are counted modulo four from reset, with slot index 0 to 3. Only the sample whose slot index equals the active phase affects the output. The other three samples have no effect.
- R3: A new value on the 2-bit phase input becomes the active phase only after the valid sample in slot 3 is taken. After reset the active phase is 0.
- R4: The error is the kept sample minus the signed set point. A zero set point locks to zero crossings and a positive set point locks to a crest level.
- R5: The proportional term is the signed product of the proportional gain and the error, arithmetically right-shifted by the shift input.
- R6: The integrator adds the signed product of the integral gain and the error, arithmetically right-shifted by the shift input, once per kept sample. The output is mid + proportional term + integrator.
- R7: The output is clamped to the signed 14-bit range, from -8192 to 8191.
- R8: When the output would be clamped, the integrator keeps its previous value and does not wind up.
- R9: The 24-bit signed integrator saturates at its own limits instead of wrapping.
- R10: While enable is low the integrator is cleared and the DAC word equals the mid value one cycle later. Samples have no effect in this state.
- R11: A kept sample driven in cycle n changes the DAC word from cycle n+2. The word does not change in cycle n+1 or after non-kept samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 14 | Signed ADC sample |
| cfg_enable | input | 1 | Loop enable |
| cfg_phase | input | 2 | Slot index to keep |
| cfg_setpoint | input | 14 | Signed set point |
| cfg_kp | input | 16 | Signed proportional gain |
| cfg_ki | input | 16 | Signed integral gain |
| cfg_shift | input | 5 | Right shift applied to both products |
| cfg_mid | input | 14 | Signed idle/offset output value |
| dac_word | output | 14 | Signed registered DAC word |

## Verification
The integrator can only be observed through the DAC word, so tests move it into states where a fault shows up. A wound-up or wrapped integrator gives an output far from the expected value on the first kept sample after the error changes sign. A skewed slot counter or phase register shows up as a DAC word driven by the wrong slot within one group. A wrong pipeline depth shows up as a changed word one cycle early or late. Each scenario therefore checks the word two cycles after the kept sample.

// File: rtl/pitrk_pkg.sv
package pitrk_pkg;
    typedef enum logic [0:0] {
        ST_HOLD  = 1'b0,
        ST_TRACK = 1'b1
    } trk_state_e;
endpackage

// File: rtl/pitrk_decim.sv
module pitrk_decim #(
    parameter int DW = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_data,
    input  logic [1:0]           cfg_phase,
    output logic                 keep,
    output logic signed [DW-1:0] keep_data
);
    logic [1:0] slot;
    logic [1:0] act_phase;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot      <= 2'd0;
            act_phase <= 2'd0;
        end else if (in_valid) begin
            slot <= slot + 2'd1;
            if (slot == 2'd3) begin
                act_phase <= cfg_phase;
            end
        end
    end

    assign keep      = in_valid && (slot == act_phase);
    assign keep_data = in_data;

    // R3: the active phase may only move when a new group starts
    p_phase_at_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (act_phase != $past(act_phase)) |-> (slot == 2'd0));
endmodule

// File: rtl/pitrk_errstage.sv
module pitrk_errstage #(
    parameter int DW = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 keep,
    input  logic signed [DW-1:0] keep_data,
    input  logic signed [DW-1:0] setpoint,
    output logic                 kept_q,
    output logic signed [DW:0]   err_q
);
    localparam int EW = DW + 1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kept_q <= 1'b0;
            err_q  <= '0;
        end else begin
            kept_q <= keep;
            if (keep) begin
                err_q <= EW'(keep_data) - EW'(setpoint);
            end
        end
    end
endmodule

// File: rtl/pitrk_pi.sv
module pitrk_pi #(
    parameter int DW  = 14,
    parameter int GW  = 16,
    parameter int IW  = 24,
    parameter int SHW = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  step,
    input  logic signed [DW:0]    err,
    input  logic signed [GW-1:0]  kp,
    input  logic signed [GW-1:0]  ki,
    input  logic [SHW-1:0]        shift,
    input  logic signed [DW-1:0]  mid,
    output logic signed [DW-1:0]  out_next
);
    localparam int EW = DW + 1;
    localparam int PW = GW + EW;
    localparam int SW = ((PW > IW) ? PW : IW) + 3;
    localparam logic signed [SW-1:0] IMAX = SW'((64'sd1 <<< (IW - 1)) - 64'sd1);
    localparam logic signed [SW-1:0] IMIN = SW'(-(64'sd1 <<< (IW - 1)));
    localparam logic signed [SW-1:0] OMAX = SW'((64'sd1 <<< (DW - 1)) - 64'sd1);
    localparam logic signed [SW-1:0] OMIN = SW'(-(64'sd1 <<< (DW - 1)));

    logic signed [IW-1:0] integ;
    logic signed [PW-1:0] p_full, i_full, p_sc, i_sc;
    logic signed [SW-1:0] i_sum, cand, u_sum;
    logic                 clamped;

    always_comb begin
        p_full = PW'(kp) * PW'(err);
        i_full = PW'(ki) * PW'(err);
        p_sc   = p_full >>> shift;
        i_sc   = i_full >>> shift;
        i_sum  = SW'(integ) + SW'(i_sc);
        if (i_sum > IMAX) begin
            cand = IMAX;
        end else if (i_sum < IMIN) begin
            cand = IMIN;
        end else begin
            cand = i_sum;
        end
        u_sum = SW'(mid) + SW'(p_sc) + cand;
        if (u_sum > OMAX) begin
            out_next = OMAX[DW-1:0];
            clamped  = 1'b1;
        end else if (u_sum < OMIN) begin
            out_next = OMIN[DW-1:0];
            clamped  = 1'b1;
        end else begin
            out_next = u_sum[DW-1:0];
            clamped  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            integ <= '0;
        end else if (clr) begin
            integ <= '0;
        end else if (step && !clamped) begin
            integ <= cand[IW-1:0];
        end
    end

    // R8: a clamped step leaves the integrator untouched
    p_no_windup_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && clamped) |=> $stable(integ));

    // R10: a clear request empties the integrator
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (integ == '0));
endmodule

// File: rtl/pi_track_loop.sv
module pi_track_loop
    import pitrk_pkg::*;
#(
    parameter int DW  = 14,
    parameter int GW  = 16,
    parameter int IW  = 24,
    parameter int SHW = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic signed [DW-1:0] smp_data,
    input  logic                 cfg_enable,
    input  logic [1:0]           cfg_phase,
    input  logic signed [DW-1:0] cfg_setpoint,
    input  logic signed [GW-1:0] cfg_kp,
    input  logic signed [GW-1:0] cfg_ki,
    input  logic [SHW-1:0]       cfg_shift,
    input  logic signed [DW-1:0] cfg_mid,
    output logic signed [DW-1:0] dac_word
);
    trk_state_e           state, state_nx;
    logic                 keep;
    logic signed [DW-1:0] keep_data;
    logic                 kept_q;
    logic signed [DW:0]   err_q;
    logic signed [DW-1:0] out_nx;
    logic                 pi_clr, pi_step;

    pitrk_decim #(.DW(DW)) u_decim (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (smp_valid),
        .in_data   (smp_data),
        .cfg_phase (cfg_phase),
        .keep      (keep),
        .keep_data (keep_data)
    );

    pitrk_errstage #(.DW(DW)) u_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .keep      (keep),
        .keep_data (keep_data),
        .setpoint  (cfg_setpoint),
        .kept_q    (kept_q),
        .err_q     (err_q)
    );

    assign pi_clr  = (state == ST_HOLD) || !cfg_enable;
    assign pi_step = (state == ST_TRACK) && cfg_enable && kept_q;

    pitrk_pi #(.DW(DW), .GW(GW), .IW(IW), .SHW(SHW)) u_pi (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (pi_clr),
        .step     (pi_step),
        .err      (err_q),
        .kp       (cfg_kp),
        .ki       (cfg_ki),
        .shift    (cfg_shift),
        .mid      (cfg_mid),
        .out_next (out_nx)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HOLD:  state_nx = cfg_enable ? ST_TRACK : ST_HOLD;
            ST_TRACK: state_nx = cfg_enable ? ST_TRACK : ST_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_HOLD;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_word <= '0;
        end else begin
            unique case (state)
                ST_HOLD: dac_word <= cfg_mid;
                ST_TRACK: begin
                    if (!cfg_enable) begin
                        dac_word <= cfg_mid;
                    end else if (kept_q) begin
                        dac_word <= out_nx;
                    end
                end
            endcase
        end
    end

    // R10: disabled loop parks the DAC at mid one cycle later
    p_hold_mid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_enable) |=> (dac_word == $past(cfg_mid)));

    // R11: no kept sample in the pipe means no output change while tracking
    p_idle_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_TRACK) && cfg_enable && !kept_q) |=> $stable(dac_word));
endmodule

// File: tb/pi_track_loop_tb.sv
module pi_track_loop_tb;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_valid = 1'b0;
    logic signed [13:0] smp_data = '0;
    logic              cfg_enable = 1'b0;
    logic [1:0]        cfg_phase = 2'd0;
    logic signed [13:0] cfg_setpoint = '0;
    logic signed [15:0] cfg_kp = '0;
    logic signed [15:0] cfg_ki = '0;
    logic [4:0]        cfg_shift = '0;
    logic signed [13:0] cfg_mid = '0;
    logic signed [13:0] dac_word;

    int checks = 0;
    int errors = 0;
    int bslot = 0;
    int bact = 0;
    bit m_track = 0;
    longint m_integ = 0;
    longint m_exp = 0;

    always #5 clk = ~clk;

    pi_track_loop u_dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .cfg_enable(cfg_enable), .cfg_phase(cfg_phase), .cfg_setpoint(cfg_setpoint),
        .cfg_kp(cfg_kp), .cfg_ki(cfg_ki), .cfg_shift(cfg_shift), .cfg_mid(cfg_mid),
        .dac_word(dac_word)
    );

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint lim(longint v, int w);
        longint hi = (longint'(1) <<< (w - 1)) - 1;
        longint lo = -(longint'(1) <<< (w - 1));
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    function automatic void model_step(longint s);
        longint e = s - longint'(cfg_setpoint);
        longint p = (longint'(cfg_kp) * e) >>> cfg_shift;
        longint ii = (longint'(cfg_ki) * e) >>> cfg_shift;
        longint cand = lim(m_integ + ii, 24);
        longint u = longint'(cfg_mid) + p + cand;
        if (u != lim(u, 14)) begin
            m_exp = lim(u, 14);
        end else begin
            m_exp = u;
            m_integ = cand;
        end
    endfunction

    task automatic push(int s);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_data = 14'(s);
        if (bslot == bact && m_track) model_step(longint'(s));
        if (bslot == 3) bact = int'(cfg_phase);
        bslot = (bslot + 1) % 4;
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            smp_valid = 1'b0;
        end
    endtask

    task automatic group(int a, int b, int c, int d);
        push(a); push(b); push(c); push(d);
        idle(2);
    endtask

    task automatic set_enable(bit e);
        @(negedge clk);
        cfg_enable = e;
        idle(2);
        m_track = e;
        m_integ = 0;
        m_exp = longint'(cfg_mid);
    endtask

    task automatic t_reset;
        cfg_mid = 14'sd321;
        idle(3);
        check("R1 reset value", longint'(dac_word), 0);
        rst_n = 1'b1;
        idle(2);
        check("R10 idle mid after reset", longint'(dac_word), 321);
    endtask

    task automatic t_hold;
        cfg_kp = 16'sd256;
        cfg_ki = 16'sd100;
        group(5000, -5000, 7000, 1);
        check("R10 samples ignored while disabled", longint'(dac_word), 321);
        cfg_mid = -14'sd50;
        idle(2);
        check("R10 mid followed while disabled", longint'(dac_word), -50);
    endtask

    task automatic t_prop;
        cfg_kp = 16'sd256; cfg_ki = '0; cfg_shift = 5'd4;
        cfg_setpoint = '0; cfg_mid = 14'sd100;
        set_enable(1'b1);
        group(300, 1, 2, 3);
        check("R5 proportional zero-cross", longint'(dac_word), 4900);
        check("R5 model", longint'(dac_word), m_exp);
        cfg_setpoint = 14'sd4000;
        group(4100, -7, 9, 0);
        check("R4 crest set point above", longint'(dac_word), 1700);
        group(3500, 0, 0, 0);
        check("R4 crest set point below", longint'(dac_word), -7900);
    endtask

    task automatic t_decim;
        longint first;
        cfg_setpoint = '0;
        group(1000, 8191, -8192, 5000);
        first = longint'(dac_word);
        check("R2 kept slot model", first, m_exp);
        group(1000, 0, 0, 0);
        check("R2 other slots ignored", longint'(dac_word), first);
    endtask

    task automatic t_phase;
        cfg_mid = '0;
        push(10);
        cfg_phase = 2'd2;
        push(20); push(30); push(40);
        idle(2);
        check("R3 old phase until boundary", longint'(dac_word), 160);
        group(11, 22, 33, 44);
        check("R3 new phase after boundary", longint'(dac_word), 528);
        cfg_phase = 2'd0;
        group(0, 0, 0, 0);
        check("R3 model", longint'(dac_word), m_exp);
    endtask

    task automatic t_integ;
        set_enable(1'b0);
        set_enable(1'b1);
        cfg_kp = '0; cfg_ki = 16'sd1024; cfg_shift = 5'd4;
        cfg_mid = '0; cfg_setpoint = '0;
        for (int k = 1; k <= 3; k++) begin
            group(10, 99, 99, 99);
            check("R6 integrator ramp", longint'(dac_word), 640 * k);
        end
    endtask

    task automatic t_clamp;
        cfg_shift = 5'd0;
        group(1000, 0, 0, 0);
        check("R7 positive clamp", longint'(dac_word), 8191);
        group(-100, 0, 0, 0);
        check("R7 negative clamp", longint'(dac_word), -8192);
        cfg_shift = 5'd10;
        group(-1000, 0, 0, 0);
        check("R8 no windup", longint'(dac_word), 920);
        check("R8 model", longint'(dac_word), m_exp);
    endtask

    task automatic t_isat;
        set_enable(1'b0);
        set_enable(1'b1);
        cfg_mid = '0; cfg_setpoint = '0; cfg_shift = 5'd0;
        cfg_kp = 16'sh8000; cfg_ki = 16'sd32767;
        group(200, 0, 0, 0);
        check("R9 first step", longint'(dac_word), -200);
        group(256, 0, 0, 0);
        check("R9 integrator saturates", longint'(dac_word), -1);
        check("R9 model", longint'(dac_word), m_exp);
    endtask

    task automatic t_latency;
        set_enable(1'b0);
        set_enable(1'b1);
        cfg_kp = 16'sd256; cfg_ki = '0; cfg_shift = 5'd4;
        idle(1);
        check("R11 start value", longint'(dac_word), 0);
        push(50);
        idle(1);
        check("R11 unchanged at n+1", longint'(dac_word), 0);
        idle(1);
        check("R11 updated at n+2", longint'(dac_word), 800);
        push(1); push(2); push(3);
        idle(2);
        check("R11 stable after non-kept", longint'(dac_word), 800);
    endtask

    initial begin
        t_reset();
        t_hold();
        t_prop();
        t_decim();
        t_phase();
        t_integ();
        t_clamp();
        t_isat();
        t_latency();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule